// File: doc/BRIEF.md
# Six-Channel Parallel ADC Readout Sequencer

This block runs a six-channel, 12-bit successive-approximation converter that presents its results on a parallel bus. While the acquisition enable is high, it pulls the convert-start line low for a short time. It then waits for the converter's busy flag to rise and fall again. After that it reads the six results, channel 1 first and channel 6 last, by driving chip-select and read low together for each one. Every result goes upward as a 16-bit word with zeros above the sample, together with a one-clock valid strobe. A channel-1 marker shows when the next word to arrive belongs to channel 1.

A small configuration port accepts 16-bit words through an active-low request and a write-done acknowledge. Setting bit 15 of a word produces a reset pulse to the converter. The block produces the same pulse by itself each time its own active-low reset is released. No conversion is started while that pulse is high. The busy input is asynchronous and passes through a two-stage synchronizer before the sequencer sees it.

Top module: `adc6_par_reader`

## Requirements
- R1: While reset is held and right after it is released, convert-start, chip-select and read are high, the valid strobe is low, write-done is high, the channel-1 marker is high and the data word is zero.
- R2: On release of the block reset, the ADC reset output stays high for exactly RST_CYC clocks (default 4) and then goes low.
- R3: A conversion starts only from idle with the enable high. Convert-start stays low for exactly CNV_CYC clocks (default 2). It never falls while busy is high or while the ADC reset output is high.
- R4: Reads begin only after busy has fallen. If busy fails to rise within BUSY_TMO clocks (default 16) of the end of convert-start, the block stops waiting and reads anyway.
- R5: Each conversion is followed by exactly six reads. In each read, chip-select and read are low together for exactly RD_CYC clocks (default 3).
- R6: At least two clocks with read high separate successive reads.
- R7: The word is captured on the last clock of the read-low window. The valid strobe lasts one clock and rises together with the read line. The word holds the sample in bits 11:0 and zeros in bits 15:12.
- R8: The channel-1 marker is high in idle and on the valid cycle of the channel-6 word, and low on the valid cycles of channels 1 to 5. Results are delivered in channel order 1 to 6.
- R9: If the enable is still high after the sixth read, the next conversion starts without a pass through idle. If it is low, the block goes idle and starts nothing further.
- R10: A low request is acknowledged by write-done going low. Write-done later returns high. No further write is taken until the request has gone high again.
- R11: A configuration word with bit 15 set raises the ADC reset output for exactly RST_CYC clocks, and write-done returns high only after that pulse has ended. A word with bit 15 clear produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acq_en | input | 1 | Acquisition enable; starts and continues conversions |
| cfg_req_n | input | 1 | Configuration write request, active low |
| cfg_data | input | 16 | Configuration word; bit 15 requests an ADC reset pulse |
| cfg_done | output | 1 | Write-done acknowledge; low while a write is in progress |
| word_out | output | 16 | Zero-extended sample word |
| word_valid | output | 1 | One-clock strobe for a new word |
| ch1_next | output | 1 | High when the next word belongs to channel 1 |
| adc_data | input | 12 | Converter parallel data bus |
| adc_busy | input | 1 | Converter busy flag (asynchronous) |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_cnv_n | output | 1 | Convert-start, active low, falling edge starts a conversion |
| adc_rst | output | 1 | Converter reset, active high |

## Verification
The bench builds the block with a read window of four clocks instead of three and a busy timeout of eight clocks. All other parameters keep their defaults. The longer read window shows that the capture clock and the valid strobe follow the parameter rather than a fixed count, and the stub returns a poison value outside the window to expose an early or late capture. The short timeout lets the no-busy case, where the stub never raises busy, finish quickly and still deliver all six words.

// File: rtl/adcrd_pkg.sv
// Package: state encodings shared by the readout sequencer and the config port.
// Assumes: nothing beyond standard SystemVerilog.
package adcrd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CNV,
        S_WAIT_HI,
        S_WAIT_LO,
        S_RD,
        S_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_ACK,
        C_WAIT
    } cfg_state_t;

endpackage

// File: rtl/adcrd_sync.sv
// Module: multi-stage synchronizer for one asynchronous level input.
// Assumes: STAGES >= 2; the output resets low.
module adcrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/adcrd_cfg.sv
// Module: configuration write port with an active-low request and acknowledge,
//         plus the converter reset pulse generator.
// Assumes: write data is stable from one clock before the request falls until
//          write-done is back high; RST_BIT selects the reset-request bit.
module adcrd_cfg
    import adcrd_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int RST_CYC = 4,
    parameter int RST_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic [WORD_W-1:0] data,
    output logic              done,
    output logic              adc_rst
);

    localparam int RW = $clog2(RST_CYC + 1);
    localparam logic [WORD_W-1:0] OTHER_MASK = ~(WORD_W'(1) << RST_BIT);

    cfg_state_t    cst;
    logic [RW-1:0] rcnt;
    logic          unused_cfg_bits;

    // Handshake state and reset-pulse down-counter; block reset arms a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst  <= C_IDLE;
            rcnt <= RW'(RST_CYC);
        end else begin
            if (rcnt != '0) rcnt <= rcnt - 1'b1;
            case (cst)
                C_IDLE: if (!req_n) begin
                    cst <= C_ACK;
                    if (data[RST_BIT]) rcnt <= RW'(RST_CYC);
                end
                C_ACK:  if (rcnt == '0) cst <= C_WAIT;
                C_WAIT: if (req_n) cst <= C_IDLE;
                default: cst <= C_IDLE;
            endcase
        end
    end

    assign done            = (cst != C_ACK);
    assign adc_rst         = (rcnt != '0);
    assign unused_cfg_bits = ^(data & OTHER_MASK);

endmodule

// File: rtl/adcrd_seq.sv
// Module: conversion and six-channel parallel read sequencer.
// Assumes: busy_s is already synchronized; hold_off blocks new conversions;
//          the data bus is stable during the read-low window.
module adcrd_seq
    import adcrd_pkg::*;
#(
    parameter int N_CH     = 6,
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16,
    parameter int RD_CYC   = 3,
    parameter int GAP_CYC  = 2,
    parameter int CNV_CYC  = 2,
    parameter int BUSY_TMO = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acq_en,
    input  logic                hold_off,
    input  logic                busy_s,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                cnv_n,
    output logic                cs_n,
    output logic                rd_n,
    output logic [WORD_W-1:0]   word,
    output logic                word_valid,
    output logic                ch1_next
);

    localparam int M1   = (RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC;
    localparam int M2   = (CNV_CYC > BUSY_TMO) ? CNV_CYC : BUSY_TMO;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int CHW  = $clog2(N_CH);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic [CHW-1:0] chan;
    logic           may_start;

    assign may_start = acq_en && !hold_off && !busy_s;

    // Main sequencer: convert, wait on busy, then read each channel in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cnt        <= '0;
            chan       <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            case (state)
                S_IDLE: if (may_start) begin
                    state <= S_CNV;
                    cnt   <= '0;
                end
                S_CNV: if (cnt == CW'(CNV_CYC - 1)) begin
                    state <= S_WAIT_HI;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                S_WAIT_HI: if (busy_s || cnt == CW'(BUSY_TMO - 1)) begin
                    state <= S_WAIT_LO;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                S_WAIT_LO: if (!busy_s) begin
                    state <= S_RD;
                    cnt   <= '0;
                    chan  <= '0;
                end
                S_RD: if (cnt == CW'(RD_CYC - 1)) begin
                    word       <= WORD_W'(adc_data);
                    word_valid <= 1'b1;
                    chan       <= (chan == CHW'(N_CH - 1)) ? '0 : chan + 1'b1;
                    state      <= S_GAP;
                    cnt        <= '0;
                end else cnt <= cnt + 1'b1;
                S_GAP: if (cnt == CW'(GAP_CYC - 1)) begin
                    cnt <= '0;
                    if (chan != '0)     state <= S_RD;
                    else if (may_start) state <= S_CNV;
                    else                state <= S_IDLE;
                end else cnt <= cnt + 1'b1;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cnv_n    = (state != S_CNV);
    assign cs_n     = (state != S_RD);
    assign rd_n     = (state != S_RD);
    assign ch1_next = (chan == '0);

endmodule

// File: rtl/adc6_par_reader.sv
// Module: top of the six-channel parallel ADC readout block.
// Assumes: adc_busy is asynchronous; the other inputs are synchronous to clk.
module adc6_par_reader #(
    parameter int N_CH     = 6,
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16,
    parameter int RD_CYC   = 3,
    parameter int GAP_CYC  = 2,
    parameter int CNV_CYC  = 2,
    parameter int BUSY_TMO = 16,
    parameter int RST_CYC  = 4,
    parameter int RST_BIT  = 15,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acq_en,
    input  logic                cfg_req_n,
    input  logic [WORD_W-1:0]   cfg_data,
    output logic                cfg_done,
    output logic [WORD_W-1:0]   word_out,
    output logic                word_valid,
    output logic                ch1_next,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                adc_busy,
    output logic                adc_cs_n,
    output logic                adc_rd_n,
    output logic                adc_cnv_n,
    output logic                adc_rst
);

    logic busy_s;

    // Bring the converter busy flag into the clock domain.
    adcrd_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_busy),
        .q     (busy_s)
    );

    // Configuration handshake and converter reset pulse.
    adcrd_cfg #(
        .WORD_W  (WORD_W),
        .RST_CYC (RST_CYC),
        .RST_BIT (RST_BIT)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (cfg_req_n),
        .data    (cfg_data),
        .done    (cfg_done),
        .adc_rst (adc_rst)
    );

    // Conversion and readout sequencing.
    adcrd_seq #(
        .N_CH     (N_CH),
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W),
        .RD_CYC   (RD_CYC),
        .GAP_CYC  (GAP_CYC),
        .CNV_CYC  (CNV_CYC),
        .BUSY_TMO (BUSY_TMO)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_en     (acq_en),
        .hold_off   (adc_rst),
        .busy_s     (busy_s),
        .adc_data   (adc_data),
        .cnv_n      (adc_cnv_n),
        .cs_n       (adc_cs_n),
        .rd_n       (adc_rd_n),
        .word       (word_out),
        .word_valid (word_valid),
        .ch1_next   (ch1_next)
    );

endmodule

// File: rtl/adc6_par_reader_chk.sv
// Module: protocol checker for the readout block, bound to its top.
// Assumes: default RST_CYC of 4 and at least two gap clocks between reads.
module adc6_par_reader_chk #(
    parameter int WORD_W   = 16,
    parameter int SAMPLE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req_n,
    input logic              cfg_done,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid,
    input logic              adc_cs_n,
    input logic              adc_rd_n,
    input logic              adc_cnv_n,
    input logic              adc_rst
);

    // Read is never low without chip-select.
    assert_rd_with_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_cs_n);

    // Upper bits of a delivered word are zero.
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((word_out >> SAMPLE_W) == '0));

    // Valid rises together with the end of the read window.
    assert_capture_at_rd_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> word_valid);

    // Valid is a single-clock strobe.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // Two high clocks precede every read.
    assert_read_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rd_n) |-> ($past(adc_rd_n, 1) && $past(adc_rd_n, 2)));

    // Convert-start low for at least two clocks.
    assert_cnv_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnv_n) |-> !$past(adc_cnv_n, 2));

    // No conversion launched while the converter is held in reset.
    assert_cnv_not_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv_n) |-> !$past(adc_rst));

    // No read overlaps convert-start.
    assert_no_read_in_cnv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cnv_n |-> adc_rd_n);

    // Converter reset pulse lasts at least four clocks.
    assert_rst_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rst) |-> ($past(adc_rst, 1) && $past(adc_rst, 2) &&
                            $past(adc_rst, 3) && $past(adc_rst, 4)));

    // Write-done only drops in answer to a request.
    assert_done_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_done) |-> !$past(cfg_req_n));

endmodule

bind adc6_par_reader adc6_par_reader_chk #(
    .WORD_W   (WORD_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_req_n  (cfg_req_n),
    .cfg_done   (cfg_done),
    .word_out   (word_out),
    .word_valid (word_valid),
    .adc_cs_n   (adc_cs_n),
    .adc_rd_n   (adc_rd_n),
    .adc_cnv_n  (adc_cnv_n),
    .adc_rst    (adc_rst)
);

// File: tb/adc6_par_reader_tb.sv
// Bench: converter stub, table-driven conversions, then directed tests.
module adc6_par_reader_tb;

    localparam int RD   = 4;
    localparam int TMO  = 8;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_en = 1'b0;
    logic        cfg_req_n = 1'b1;
    logic [15:0] cfg_data = 16'h0;
    logic        cfg_done, word_valid, ch1_next;
    logic [15:0] word_out;
    logic [11:0] adc_data;
    logic        adc_busy;
    logic        adc_cs_n, adc_rd_n, adc_cnv_n, adc_rst;

    always #4 clk = ~clk;

    adc6_par_reader #(.RD_CYC(RD), .BUSY_TMO(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .cfg_req_n(cfg_req_n),
        .cfg_data(cfg_data), .cfg_done(cfg_done), .word_out(word_out),
        .word_valid(word_valid), .ch1_next(ch1_next), .adc_data(adc_data),
        .adc_busy(adc_busy), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_cnv_n(adc_cnv_n), .adc_rst(adc_rst));

    // Converter stub: busy after convert-start, then six results by read count.
    logic [11:0] samp [6];
    logic        nobusy = 1'b0;
    logic        stub_busy = 1'b0;
    int          bcnt = 0;
    int          ridx = 0;
    logic        s_prev_cnv = 1'b1, s_prev_rd = 1'b1;

    always @(posedge clk) begin
        s_prev_cnv <= adc_cnv_n;
        s_prev_rd  <= adc_rd_n;
        if (s_prev_cnv && !adc_cnv_n) begin
            ridx <= 0;
            if (!nobusy) begin stub_busy <= 1'b1; bcnt <= 12; end
        end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) stub_busy <= 1'b0;
        end
        if (!s_prev_rd && adc_rd_n) ridx <= ridx + 1;
    end
    assign adc_busy = stub_busy;
    assign adc_data = (!adc_cs_n && !adc_rd_n && ridx < 6) ? samp[ridx] : 12'hBAD;

    // Monitor, sampled on the falling edge.
    int   cyc = 0;
    int   n_words = 0, n_cnv = 0, n_rst_pulses = 0, n_done_fall = 0;
    logic [15:0] w_log [64];
    logic        s_log [64];
    int   rd_run = 0, hi_run = 0, cnv_run = 0, rst_run = 0, last_rst_run = 0;
    int   rd_bad = 0, gap_bad = 0, cnv_bad = 0;
    int   cnv_in_busy = 0, cnv_in_rst = 0, rd_in_busy = 0;
    logic had_low = 1'b0;
    logic m_rd = 1'b1, m_cnv = 1'b1, m_rst = 1'b0, m_done = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                w_log[n_words % 64] = word_out;
                s_log[n_words % 64] = ch1_next;
                n_words++;
            end
            if (!adc_rd_n) begin
                if (m_rd) begin
                    if (had_low && hi_run < 2) gap_bad++;
                    if (stub_busy) rd_in_busy++;
                    rd_run = 0;
                end
                rd_run++;
            end else begin
                if (!m_rd) begin
                    if (rd_run != RD) rd_bad++;
                    had_low = 1'b1;
                    hi_run = 0;
                end
                hi_run++;
            end
            if (!adc_cnv_n) begin
                if (m_cnv) begin
                    n_cnv++;
                    cnv_run = 0;
                    if (stub_busy) cnv_in_busy++;
                    if (m_rst) cnv_in_rst++;
                end
                cnv_run++;
            end else if (!m_cnv && cnv_run != 2) cnv_bad++;
            if (adc_rst) rst_run++;
            else if (rst_run != 0) begin last_rst_run = rst_run; rst_run = 0; n_rst_pulses++; end
            if (m_done && !cfg_done) n_done_fall++;
        end
        m_rd = adc_rd_n; m_cnv = adc_cnv_n; m_rst = adc_rst; m_done = cfg_done;
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_words(input int target);
        for (int i = 0; i < 600 && n_words < target; i++) @(negedge clk);
    endtask

    task automatic wait_cnv(input int target);
        for (int i = 0; i < 200 && n_cnv < target; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [15:0] d, input int pulses_exp);
        int   p0, f0, lo_seen;
        logic rst_at_done;
        p0 = n_rst_pulses; f0 = n_done_fall; lo_seen = 0;
        @(negedge clk) cfg_data = d;
        @(negedge clk) cfg_req_n = 1'b0;
        for (int i = 0; i < 20 && cfg_done; i++) @(negedge clk);
        lo_seen = cfg_done ? 0 : 1;
        for (int i = 0; i < 20 && !cfg_done; i++) @(negedge clk);
        rst_at_done = adc_rst;
        chk("R10", "write-done dropped", lo_seen, 1);
        chk("R10", "write-done returned", cfg_done, 1);
        chk("R11", "reset low when done returns", rst_at_done, 0);
        nclk(5);
        chk("R10", "no second write while request held", n_done_fall - f0, 1);
        cfg_req_n = 1'b1;
        nclk(3);
        chk("R11", "reset pulse count", n_rst_pulses - p0, pulses_exp);
        if (pulses_exp != 0) chk("R11", "reset pulse width", last_rst_run, RSTC);
    endtask

    // Stimulus table: bit 72 selects a stub that never raises busy; ch1 in bits 11:0.
    localparam logic [72:0] VEC [4] = '{
        {1'b0, 12'h666, 12'h555, 12'h444, 12'h333, 12'h222, 12'h111},
        {1'b0, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 12'h000},
        {1'b1, 12'hABC, 12'h123, 12'h800, 12'h7FF, 12'h001, 12'hFFE},
        {1'b0, 12'h5A5, 12'hA5A, 12'h0F0, 12'hF0F, 12'hC3C, 12'h3C3}
    };

    initial begin : watchdog
        wait (cyc >= 150000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int n0, c0, len;
        for (int k = 0; k < 6; k++) samp[k] = 12'h000;
        nclk(5);
        // R1: state while reset is held.
        chk("R1", "cnv_n in reset", adc_cnv_n, 1);
        chk("R1", "rd_n in reset", adc_rd_n, 1);
        chk("R1", "cs_n in reset", adc_cs_n, 1);
        // R2: count ADC reset high clocks from the release.
        rst_n = 1'b1;
        len = 0;
        for (int i = 0; i < 20 && adc_rst; i++) begin len++; @(negedge clk); end
        chk("R2", "post-reset pulse width", len, RSTC);
        chk("R1", "valid after reset", word_valid, 0);
        chk("R1", "done after reset", cfg_done, 1);
        chk("R1", "ch1 marker after reset", ch1_next, 1);
        chk("R1", "word after reset", word_out, 0);
        nclk(3);

        // Table walk: one conversion per entry.
        for (int v = 0; v < 4; v++) begin
            for (int k = 0; k < 6; k++) samp[k] = VEC[v][12*k +: 12];
            nobusy = VEC[v][72];
            n0 = n_words; c0 = n_cnv;
            acq_en = 1'b1;
            wait_cnv(c0 + 1);
            acq_en = 1'b0;
            wait_words(n0 + 6);
            nclk(20);
            chk(nobusy ? "R4" : "R5", "words per conversion", n_words - n0, 6);
            for (int k = 0; k < 6; k++) begin
                chk("R7", "word value", w_log[(n0 + k) % 64], {4'h0, VEC[v][12*k +: 12]});
                chk("R8", "ch1 marker at valid", s_log[(n0 + k) % 64], (k == 5) ? 1 : 0);
            end
        end

        // R9: continuous acquisition for two conversions, then stop.
        n0 = n_words; c0 = n_cnv;
        acq_en = 1'b1;
        wait_cnv(c0 + 2);
        acq_en = 1'b0;
        wait_words(n0 + 12);
        nclk(100);
        chk("R9", "conversions while enabled", n_cnv - c0, 2);
        chk("R9", "words while enabled", n_words - n0, 12);
        chk("R9", "idle after enable drops", adc_cs_n, 1);

        // R10/R11: config words with and without the reset bit.
        cfg_write(16'h7FFF, 0);
        cfg_write(16'h8000, 1);

        // R3: enable raised during a config reset pulse waits for its end.
        c0 = n_cnv; n0 = n_words;
        @(negedge clk) cfg_data = 16'hFFFF;
        @(negedge clk) cfg_req_n = 1'b0;
        for (int i = 0; i < 10 && !adc_rst; i++) @(negedge clk);
        acq_en = 1'b1;
        for (int i = 0; i < 10 && adc_rst; i++) begin
            if (n_cnv != c0) chk("R3", "conversion during ADC reset", n_cnv - c0, 0);
            @(negedge clk);
        end
        wait_cnv(c0 + 1);
        acq_en = 1'b0;
        cfg_req_n = 1'b1;
        wait_words(n0 + 6);
        nclk(20);
        chk("R3", "conversion after reset pulse", n_cnv - c0, 1);

        // Protocol counters gathered over the whole run.
        chk("R3", "convert-start width errors", cnv_bad, 0);
        chk("R3", "convert-start while busy", cnv_in_busy, 0);
        chk("R3", "convert-start while ADC reset", cnv_in_rst, 0);
        chk("R4", "read while busy", rd_in_busy, 0);
        chk("R5", "read width errors", rd_bad, 0);
        chk("R6", "read gap errors", gap_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule